// File: doc/BRIEF.md
# Serial Readout Slave for Captured Data Lines

This block is a byte-oriented I2C slave that runs from a fast system clock and oversamples the two bus lines. A host writes a single byte to it to set the operating mode. The host then reads captured data bytes back in a stream whose length depends on that mode. There is no register subaddress. A write always lands in the control register, and a read always starts at the first byte of the transfer bank.

The transfer bank holds up to 13 bytes. An acquisition engine fills it through a one-cycle load strobe. From each START to the following STOP the block asserts a busy flag. While busy is high, load strobes are discarded, so a host read never sees a mix of old and new bytes. The device address is fixed except for its lowest bit, which comes from a chip-select pin. SDA is driven through an open-drain style output with an active-low enable.

Top module: `xfer_i2c_slave`

## Requirements
- R1: After reset the control register reads 0x00, busy is low and SDA is released (sda_oe_no = 1).
- R2: The 7-bit device address is 0x10 with bit 0 replaced by cs_sel_i, which gives byte values 0x20/0x21 or 0x22/0x23. The slave acknowledges only an address byte whose upper seven bits match.
- R3: After a non-matching address the slave drives SDA low on no clock until the next START, and the control register is left unchanged.
- R4: The first byte after a matching write address is stored in the control register and acknowledged. Any further byte in the same transaction is not acknowledged and does not alter the register.
- R5: After a matching read address the slave sends bank byte 0 MSB first. Each master ACK moves to the next byte.
- R6: The readable count follows control bits 1, 0 and 2. Bit 1 = 0 gives 9 bytes. Bit 1 = 1 with bit 0 = 0 gives 13. Bits 1,0 = 1,1 with bit 2 = 0 gives 13. Bits 2,1,0 = 1,1,1 gives 8. Bytes read beyond the count return 0xFF. Bits 3 to 7 do not affect the count.
- R7: A master NACK ends the read. The slave releases SDA and drives nothing until the next START.
- R8: Every START, including a repeated START, returns the read pointer to byte 0.
- R9: busy_o is high from a START until the following STOP. A load strobe while busy is dropped. A strobe while not busy loads all bank bytes in one cycle (byte i from acq_data_i[8i+7:8i]).
- R10: START and STOP are SDA falling and rising edges while SCL is high. Either one aborts a transfer in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_no | output | 1 | 0 pulls SDA low, 1 releases it |
| cs_sel_i | input | 1 | Selects the lowest device address bit |
| acq_we_i | input | 1 | Load strobe from the acquisition engine |
| acq_data_i | input | 104 | New bank contents, byte i at bits 8i+7:8i |
| ctrl_o | output | 8 | Control register |
| busy_o | output | 1 | Bus access in progress, bank frozen |

## Verification
The address byte is swept over a window of eight 7-bit values around the match, once for each chip-select level. This shows that the acknowledge and the control write depend on an exact match only, and it confirms that the slave stays silent on every miss. All eight mode selections are written with test bits mixed in, and each is followed by a 14-byte read with a fresh bank pattern. This separates the four byte counts and the 0xFF padding, and it catches a wrong byte order. A read cut short by an early NACK, a repeated START, an aborted address and load strobes issued inside and outside a transaction separate pointer reset, release after NACK, and the freeze of the bank.

// File: rtl/xfer_i2c_pkg.sv
package xfer_i2c_pkg;

  localparam int unsigned FLD_SRC  = 0;
  localparam int unsigned FLD_MODE = 1;
  localparam int unsigned FLD_HDR  = 2;

  localparam int unsigned CNT_VPS  = 9;
  localparam int unsigned CNT_FMT2 = 13;
  localparam int unsigned CNT_FMT1 = 13;
  localparam int unsigned CNT_HDR  = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_WR, ST_TX, ST_MACK, ST_SKIP
  } slv_st_e;

  typedef enum logic [1:0] {
    ACK_RD, ACK_WR, ACK_CTRL
  } ack_kind_e;

  function automatic int unsigned avail_bytes(input logic [7:0] c);
    if (!c[FLD_MODE])     return CNT_VPS;
    else if (!c[FLD_SRC]) return CNT_FMT2;
    else if (!c[FLD_HDR]) return CNT_FMT1;
    else                  return CNT_HDR;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned NLINE = 2;

  logic [NLINE-1:0] raw;
  logic [NLINE-1:0] lvl;
  logic [NLINE-1:0] dly;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [STAGES-1:0] sq;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sq     <= '1;
        dly[g] <= 1'b1;
      end else begin
        sq     <= {sq[STAGES-2:0], raw[g]};
        dly[g] <= sq[STAGES-1];
      end
    end
    assign lvl[g] = sq[STAGES-1];
  end

  assign sda_o      = lvl[1];
  assign scl_rise_o = lvl[0] & ~dly[0];
  assign scl_fall_o = ~lvl[0] & dly[0];
  // both SCL samples high so a line edge near the SCL edge is not a condition
  assign start_o    = lvl[0] & dly[0] & dly[1] & ~lvl[1];
  assign stop_o     = lvl[0] & dly[0] & ~dly[1] & lvl[1];

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import xfer_i2c_pkg::*;
#(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [6:0]       dev_addr_i,
  input  logic [7:0]       rd_byte_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [7:0]       ctrl_o,
  output logic             busy_o,
  output logic             drv_low_o
);
  slv_st_e    st_q;
  ack_kind_e  ack_q;
  logic       ack_on_q, mack_q, drv_q, busy_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, tx_q, ctrl_q;
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ack_q    <= ACK_WR;
      ack_on_q <= 1'b0;
      mack_q   <= 1'b0;
      drv_q    <= 1'b0;
      busy_q   <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      ctrl_q   <= '0;
      ptr_q    <= '0;
    end else if (start_i) begin
      st_q     <= ST_ADDR;
      bit_q    <= '0;
      ptr_q    <= '0;
      drv_q    <= 1'b0;
      ack_on_q <= 1'b0;
      mack_q   <= 1'b0;
      busy_q   <= 1'b1;
    end else if (stop_i) begin
      st_q   <= ST_IDLE;
      drv_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: if (scl_rise_i) begin
          sh_q  <= {sh_q[6:0], sda_i};
          bit_q <= bit_q + 4'd1;
          if (bit_q == 4'd7) begin
            if (sh_q[6:0] == dev_addr_i) begin
              st_q  <= ST_ACK;
              ack_q <= sda_i ? ACK_RD : ACK_WR;
            end else begin
              st_q <= ST_SKIP;
            end
          end
        end
        ST_WR: if (scl_rise_i) begin
          sh_q  <= {sh_q[6:0], sda_i};
          bit_q <= bit_q + 4'd1;
          if (bit_q == 4'd7) begin
            ctrl_q <= {sh_q[6:0], sda_i};
            st_q   <= ST_ACK;
            ack_q  <= ACK_CTRL;
          end
        end
        ST_ACK: if (scl_fall_i) begin
          if (!ack_on_q) begin
            drv_q    <= 1'b1;
            ack_on_q <= 1'b1;
          end else begin
            ack_on_q <= 1'b0;
            bit_q    <= '0;
            unique case (ack_q)
              ACK_RD: begin
                tx_q  <= {rd_byte_i[6:0], 1'b0};
                drv_q <= ~rd_byte_i[7];
                st_q  <= ST_TX;
              end
              ACK_WR: begin
                drv_q <= 1'b0;
                st_q  <= ST_WR;
              end
              default: begin
                drv_q <= 1'b0;
                st_q  <= ST_SKIP;
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_rise_i) bit_q <= bit_q + 4'd1;
          if (scl_fall_i) begin
            if (bit_q == 4'd8) begin
              drv_q <= 1'b0;
              st_q  <= ST_MACK;
            end else begin
              drv_q <= ~tx_q[7];
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            if (!sda_i) begin
              mack_q <= 1'b1;
              if (ptr_q != {PTR_W{1'b1}}) ptr_q <= ptr_q + PTR_W'(1);
            end else begin
              st_q <= ST_SKIP;
            end
          end else if (scl_fall_i && mack_q) begin
            mack_q <= 1'b0;
            bit_q  <= '0;
            tx_q   <= {rd_byte_i[6:0], 1'b0};
            drv_q  <= ~rd_byte_i[7];
            st_q   <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  assign ptr_o     = ptr_q;
  assign ctrl_o    = ctrl_q;
  assign busy_o    = busy_q;
  assign drv_low_o = drv_q;

  assert_ptr_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ptr_o == '0));
  assert_busy_on_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  assert_quiet_skip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP || st_q == ST_IDLE) |-> !drv_low_o);
  assert_ctrl_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_WR) |=> $stable(ctrl_o));
  assert_busy_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !busy_o);

endmodule

// File: rtl/xfer_bank.sv
module xfer_bank
  import xfer_i2c_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 13,
  parameter int unsigned PTR_W     = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   busy_i,
  input  logic                   acq_we_i,
  input  logic [NUM_BYTES*8-1:0] acq_data_i,
  input  logic [7:0]             ctrl_i,
  input  logic [PTR_W-1:0]       ptr_i,
  output logic [7:0]             rd_byte_o
);
  logic [NUM_BYTES-1:0][7:0] mem_q;
  int unsigned               want;
  logic [PTR_W-1:0]          cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (acq_we_i && !busy_i) begin
      for (int i = 0; i < NUM_BYTES; i++) mem_q[i] <= acq_data_i[i*8 +: 8];
    end
  end

  always_comb begin
    want = avail_bytes(ctrl_i);
    cnt  = (want > NUM_BYTES) ? PTR_W'(NUM_BYTES) : PTR_W'(want);
    rd_byte_o = 8'hFF;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (ptr_i == PTR_W'(i) && ptr_i < cnt) rd_byte_o = mem_q[i];
    end
  end

  assert_frozen_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(mem_q));

endmodule

// File: rtl/xfer_i2c_slave.sv
module xfer_i2c_slave
  import xfer_i2c_pkg::*;
#(
  parameter int unsigned NUM_BYTES  = 13,
  parameter logic [6:0]  BASE_ADDR7 = 7'h10,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_no,
  input  logic                   cs_sel_i,
  input  logic                   acq_we_i,
  input  logic [NUM_BYTES*8-1:0] acq_data_i,
  output logic [7:0]             ctrl_o,
  output logic                   busy_o
);
  localparam int unsigned PTR_W = $clog2(NUM_BYTES + 1);

  logic sda_s, scl_rise, scl_fall, start_c, stop_c, drv_low;
  logic [PTR_W-1:0] ptr;
  logic [7:0] rd_byte;
  logic [6:0] dev_addr;

  assign dev_addr = {BASE_ADDR7[6:1], cs_sel_i};

  i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2c_slave_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c), .dev_addr_i(dev_addr), .rd_byte_i(rd_byte),
    .ptr_o(ptr), .ctrl_o, .busy_o, .drv_low_o(drv_low)
  );

  xfer_bank #(.NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) u_bank (
    .clk_i, .rst_ni, .busy_i(busy_o), .acq_we_i, .acq_data_i,
    .ctrl_i(ctrl_o), .ptr_i(ptr), .rd_byte_o(rd_byte)
  );

  assign sda_oe_no = ~drv_low;

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (sda_oe_no && !busy_o));

endmodule

// File: tb/tb_xfer_i2c_slave.sv
module tb_xfer_i2c_slave;
  localparam int NB = 13;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1, cs = 1'b0, acq_we = 1'b0;
  logic [NB*8-1:0] acq_data = '0;
  logic sda_oe_no, busy;
  logic [7:0] ctrl;
  wire sda_bus = m_sda & sda_oe_no;

  int compared = 0, mismatched = 0, drive_cnt = 0;
  logic [7:0] bank_m [NB];

  always #2.5 clk = ~clk;

  xfer_i2c_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_no(sda_oe_no),
    .cs_sel_i(cs), .acq_we_i(acq_we), .acq_data_i(acq_data), .ctrl_o(ctrl), .busy_o(busy)
  );

  always @(negedge clk) if (!sda_oe_no) drive_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bit_clk(input logic v, output logic s);
    m_sda = v; wq(); scl = 1'b1; wq(); s = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
    bit_clk(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bit_clk(1'b1, s);
      b = {b[6:0], s};
    end
    bit_clk(~m_ack, s);
  endtask

  task automatic load_bank(input int seed);
    for (int i = 0; i < NB; i++) begin
      bank_m[i] = 8'((i * 29 + seed * 7 + 3) & 255);
      acq_data[i*8 +: 8] = bank_m[i];
    end
    acq_we = 1'b1; @(negedge clk); acq_we = 1'b0; @(negedge clk);
  endtask

  function automatic int exp_cnt(input logic [7:0] c);
    if (!c[1]) return 9;
    if (!c[0]) return 13;
    if (!c[2]) return 13;
    return 8;
  endfunction

  task automatic write_ctrl(input logic [7:0] v);
    logic a;
    i2c_start();
    send_byte({6'b001000, cs, 1'b0}, a); chk("R2 write addr ack", a, 1);
    send_byte(v, a); chk("R4 ctrl ack", a, 1);
    i2c_stop();
    chk("R4 ctrl value", ctrl, v);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    logic [7:0] v;
    logic [7:0] ctrl_m;
    int d0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ctrl reset", ctrl, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 sda released", sda_oe_no, 1);
    ctrl_m = '0;

    // R2 R3 R4: address sweep on both chip-select levels
    for (int c = 0; c < 2; c++) begin
      cs = c[0];
      for (int ad = 7'h0C; ad <= 7'h13; ad++) begin
        logic hit;
        hit = (ad == (7'h10 | c));
        d0 = drive_cnt;
        i2c_start();
        send_byte({ad[6:0], 1'b0}, a);
        chk("R2 addr ack on match only", a, hit);
        v = {1'b1, ad[6:0]} ^ 8'(c);
        send_byte(v, a);
        i2c_stop();
        if (hit) ctrl_m = v;
        chk("R4 ctrl after sweep write", ctrl, ctrl_m);
        if (!hit) chk("R3 no drive after miss", drive_cnt - d0, 0);
      end
    end

    // R4: second data byte is not acknowledged
    cs = 1'b0;
    i2c_start();
    send_byte(8'h20, a);
    send_byte(8'h5A, a); chk("R4 first byte ack", a, 1);
    send_byte(8'hC3, a); chk("R4 extra byte nack", a, 0);
    i2c_stop();
    chk("R4 extra byte ignored", ctrl, 8'h5A);

    // R5 R6: all mode selections, with test bits mixed in
    for (int m = 0; m < 8; m++) begin
      v = 8'(m) | ((m % 2 == 1) ? 8'hA8 : 8'h50);
      write_ctrl(v);
      load_bank(m + 1);
      i2c_start();
      send_byte(8'h21, a); chk("R5 read addr ack", a, 1);
      for (int i = 0; i < 14; i++) begin
        recv_byte(i != 13, b);
        chk($sformatf("R6 mode %0d byte %0d", m, i), b,
            (i < exp_cnt(v)) ? bank_m[i] : 8'hFF);
      end
      i2c_stop();
    end

    // R7 R8: early NACK, silence, then pointer back at byte 0
    write_ctrl(8'h02);
    i2c_start();
    send_byte(8'h21, a);
    recv_byte(1'b1, b); chk("R5 first byte", b, bank_m[0]);
    recv_byte(1'b0, b); chk("R5 second byte", b, bank_m[1]);
    d0 = drive_cnt;
    recv_byte(1'b0, b);
    chk("R7 no drive after nack", drive_cnt - d0, 0);
    chk("R7 released bits read high", b, 8'hFF);
    i2c_start();
    send_byte(8'h21, a); chk("R8 repeated start ack", a, 1);
    recv_byte(1'b0, b); chk("R8 pointer reset on repeated start", b, bank_m[0]);
    i2c_stop();

    // R10: STOP and START inside an address byte abort it
    i2c_start();
    for (int i = 0; i < 4; i++) bit_clk(1'b0, a);
    i2c_stop();
    chk("R10 busy low after abort stop", busy, 0);
    chk("R10 released after abort", sda_oe_no, 1);
    i2c_start();
    for (int i = 0; i < 3; i++) bit_clk(1'b1, a);
    i2c_start();
    send_byte(8'h21, a); chk("R10 start mid-byte restarts", a, 1);
    recv_byte(1'b0, b); chk("R10 read after restart", b, bank_m[0]);
    i2c_stop();

    // R9: load strobe inside a transaction is dropped, outside it lands
    i2c_start();
    chk("R9 busy after start", busy, 1);
    send_byte(8'h21, a);
    recv_byte(1'b1, b);
    for (int i = 0; i < NB; i++) acq_data[i*8 +: 8] = 8'(i + 8'h90);
    acq_we = 1'b1; @(negedge clk); acq_we = 1'b0;
    recv_byte(1'b0, b); chk("R9 old data mid read", b, bank_m[1]);
    i2c_stop();
    chk("R9 busy cleared by stop", busy, 0);
    i2c_start();
    send_byte(8'h21, a);
    recv_byte(1'b1, b); chk("R9 dropped load byte 0", b, bank_m[0]);
    recv_byte(1'b0, b); chk("R9 dropped load byte 1", b, bank_m[1]);
    i2c_stop();
    load_bank(40);
    i2c_start();
    send_byte(8'h21, a);
    for (int i = 0; i < 9; i++) begin
      recv_byte(i != 8, b);
      chk("R9 idle load visible", b, bank_m[i]);
    end
    i2c_stop();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule